// File: doc/BRIEF.md
# Local Midrange Adaptive Binarizer

This block turns a grayscale pixel stream into a one-bit object/background map. Each incoming pixel arrives together with the largest and smallest values found in its neighborhood. These come from two running max/min filters that work side by side on the same stream. The block forms the midpoint of that pair as a per-pixel threshold, and the spread of the pair as a local contrast figure.

When the contrast reaches a programmable limit, the pixel is compared against its local threshold. When the neighborhood is too flat, its pixels are all put in one class, chosen from where the neighborhood's midpoint lies relative to mid-gray. The upstream filters align the pixel with its neighborhood statistics; this block assumes `lmax_i >= lmin_i` on every valid beat.

Top module: `mrb_binarizer`

## Requirements
- R1: While `rst_ni` is low and after its release, before the first valid beat, `valid_o` is 0 and `obj_o` is 0.
- R2: `valid_o` equals the value `valid_i` had one clock cycle earlier.
- R3: The threshold is floor((`lmax_i` + `lmin_i`) / 2), formed without overflow (max 255, min 253 gives 254).
- R4: When the contrast is not low, `obj_o` is 1 (object) exactly when `pix_i` >= threshold, else 0 (background), one cycle after the valid beat.
- R5: Contrast is `lmax_i` - `lmin_i`. It is low only when strictly below `contrast_thr_i`. A contrast equal to the limit takes the normal comparison.
- R6: When the contrast is low, `obj_o` is 1 exactly when the threshold is >= 128 (mid-gray, 1 << (PIX_W-1)), whatever `pix_i` is.
- R7: A cycle with `valid_i` low leaves `obj_o` unchanged.
- R8: With `contrast_thr_i` = 0 no neighborhood is low contrast, even a fully flat one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input beat qualifier |
| pix_i | input | PIX_W | Pixel value |
| lmax_i | input | PIX_W | Neighborhood maximum |
| lmin_i | input | PIX_W | Neighborhood minimum |
| contrast_thr_i | input | PIX_W | Low-contrast limit |
| valid_o | output | 1 | Output beat qualifier |
| obj_o | output | 1 | 1 = object, 0 = background |

## Verification
The block holds only one result register and one valid flag. A wrong internal value therefore shows at the ports on the very next cycle, as a flipped `obj_o` or a missing or extra `valid_o`. A truncated threshold sum would show first on bright neighborhoods near full scale. An off-by-one in the contrast comparison shows when the contrast is exactly at the limit. A wrong mid-gray test shows when the threshold sits at 127 or 128. The stimulus sits on each of these edges. It also checks that idle cycles keep the last class.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
  localparam int unsigned PIX_W_DEF = 8;
endpackage

// File: rtl/mrb_stats.sv
module mrb_stats #(
  parameter int unsigned PIX_W = mrb_pkg::PIX_W_DEF
) (
  input  logic [PIX_W-1:0] lmax_i,
  input  logic [PIX_W-1:0] lmin_i,
  output logic [PIX_W-1:0] mid_o,
  output logic [PIX_W-1:0] contrast_o
);
  logic [PIX_W:0] sum;

  // one extra bit keeps the carry, shift halves it
  always_comb begin
    sum        = {1'b0, lmax_i} + {1'b0, lmin_i};
    mid_o      = sum[PIX_W:1];
    contrast_o = lmax_i - lmin_i;
  end

  always_comb begin
    if (lmax_i >= lmin_i)
      assert_mid_in_range_R3: assert (mid_o >= lmin_i && mid_o <= lmax_i);
  end
endmodule

// File: rtl/mrb_decide.sv
module mrb_decide #(
  parameter int unsigned PIX_W = mrb_pkg::PIX_W_DEF
) (
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] mid_i,
  input  logic [PIX_W-1:0] contrast_i,
  input  logic [PIX_W-1:0] contrast_thr_i,
  output logic             obj_o
);
  localparam logic [PIX_W-1:0] MID_GRAY = PIX_W'(1) << (PIX_W - 1);

  logic low_contrast;

  always_comb begin
    low_contrast = contrast_i < contrast_thr_i;
    if (low_contrast) obj_o = mid_i >= MID_GRAY;
    else              obj_o = pix_i >= mid_i;
  end
endmodule

// File: rtl/mrb_binarizer.sv
module mrb_binarizer #(
  parameter int unsigned PIX_W = mrb_pkg::PIX_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] lmax_i,
  input  logic [PIX_W-1:0] lmin_i,
  input  logic [PIX_W-1:0] contrast_thr_i,
  output logic             valid_o,
  output logic             obj_o
);
  localparam logic [PIX_W-1:0] MID_GRAY = PIX_W'(1) << (PIX_W - 1);

  logic [PIX_W-1:0] mid;
  logic [PIX_W-1:0] contrast;
  logic             obj_next;

  mrb_stats #(.PIX_W(PIX_W)) u_stats (
    .lmax_i    (lmax_i),
    .lmin_i    (lmin_i),
    .mid_o     (mid),
    .contrast_o(contrast)
  );

  mrb_decide #(.PIX_W(PIX_W)) u_decide (
    .pix_i         (pix_i),
    .mid_i         (mid),
    .contrast_i    (contrast),
    .contrast_thr_i(contrast_thr_i),
    .obj_o         (obj_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      obj_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) obj_o <= obj_next;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_idle_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(obj_o) && !valid_o);

  assert_bright_pix_object_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && lmax_i >= lmin_i && (lmax_i - lmin_i) >= contrast_thr_i && pix_i >= lmax_i)
      |=> obj_o);

  assert_dark_pix_background_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && lmax_i >= lmin_i && (lmax_i - lmin_i) >= contrast_thr_i && pix_i < lmin_i)
      |=> !obj_o);

  assert_flat_bright_object_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && lmax_i >= lmin_i && (lmax_i - lmin_i) < contrast_thr_i && lmin_i >= MID_GRAY)
      |=> obj_o);

  assert_flat_dark_background_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && lmax_i >= lmin_i && (lmax_i - lmin_i) < contrast_thr_i && lmax_i < MID_GRAY)
      |=> !obj_o);
endmodule

// File: tb/mrb_binarizer_bench.sv
module mrb_binarizer_bench;
  localparam int unsigned PIX_W = 8;
  localparam int NVEC = 14;

  // {pix, lmax, lmin, contrast_thr, expected obj}
  localparam logic [32:0] VEC [NVEC] = '{
    {8'd100, 8'd200, 8'd0,   8'd10, 1'b1},  // R4 at threshold
    {8'd99,  8'd200, 8'd0,   8'd10, 1'b0},  // R4 one below
    {8'd254, 8'd255, 8'd253, 8'd0,  1'b1},  // R3 no overflow
    {8'd253, 8'd255, 8'd253, 8'd0,  1'b0},  // R3
    {8'd255, 8'd255, 8'd255, 8'd0,  1'b1},  // R8 flat, C=0
    {8'd50,  8'd60,  8'd50,  8'd10, 1'b0},  // R5 contrast == C
    {8'd50,  8'd60,  8'd51,  8'd10, 1'b0},  // R5 low, mid 55
    {8'd60,  8'd60,  8'd51,  8'd10, 1'b0},  // R6 pix ignored
    {8'd120, 8'd140, 8'd120, 8'd30, 1'b1},  // R6 mid 130
    {8'd0,   8'd129, 8'd127, 8'd5,  1'b1},  // R6 mid 128
    {8'd255, 8'd128, 8'd127, 8'd5,  1'b0},  // R6 mid 127
    {8'd201, 8'd255, 8'd148, 8'd50, 1'b1},  // R3 R4 mid 201
    {8'd200, 8'd255, 8'd148, 8'd50, 1'b0},  // R4
    {8'd0,   8'd0,   8'd0,   8'd1,  1'b0}   // R6 flat black
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid_in = 1'b0;
  logic [PIX_W-1:0] pix = '0, lmax = '0, lmin = '0, cthr = '0;
  logic             valid_out, obj;
  int               errors = 0;
  int               checks = 0;
  bit               done = 1'b0;

  always #10 clk = ~clk;

  mrb_binarizer #(.PIX_W(PIX_W)) u_mrb_binarizer (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .valid_i       (valid_in),
    .pix_i         (pix),
    .lmax_i        (lmax),
    .lmin_i        (lmin),
    .contrast_thr_i(cthr),
    .valid_o       (valid_out),
    .obj_o         (obj)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [32:0] e);
    valid_in = v;
    pix  = e[32:25];
    lmax = e[24:17];
    lmin = e[16:9];
    cthr = e[8:1];
  endtask

  initial begin
    @(negedge clk);
    check("R1 valid in reset", valid_out, 1'b0);
    check("R1 obj in reset", obj, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", valid_out, 1'b0);
    check("R1 obj after reset", obj, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      drive(1'b1, VEC[i]);
      @(negedge clk);
      check("R2 valid follows", valid_out, 1'b1);
      check($sformatf("R4/R6 vector %0d", i), obj, VEC[i][0]);
    end

    // R7: object state held across idle beat whose data would give 0
    drive(1'b1, {8'd200, 8'd200, 8'd0, 8'd10, 1'b1});
    @(negedge clk);
    check("R7 setup", obj, 1'b1);
    drive(1'b0, {8'd0, 8'd200, 8'd0, 8'd10, 1'b0});
    @(negedge clk);
    check("R2 valid drops", valid_out, 1'b0);
    check("R7 obj held", obj, 1'b1);
    @(negedge clk);
    check("R7 obj held 2", obj, 1'b1);

    // R8: flat neighborhood with C=0 uses pixel compare
    drive(1'b1, {8'd9, 8'd10, 8'd10, 8'd0, 1'b0});
    @(negedge clk);
    check("R8 flat C=0 below", obj, 1'b0);
    drive(1'b1, {8'd10, 8'd10, 8'd10, 8'd0, 1'b1});
    @(negedge clk);
    check("R8 flat C=0 equal", obj, 1'b1);

    // R1: asynchronous reset mid-stream
    #3 rst_n = 1'b0;
    #2;
    check("R1 async valid", valid_out, 1'b0);
    check("R1 async obj", obj, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule